// File: doc/BRIEF.md
# Idle-Aware Clock Enable Controller

This block decides, every cycle of an always-on controller clock, which of four clock domains in a processor subsystem may run. Software programs two 16-bit registers over a small request/response slave port. The idle-policy register picks, for each domain, whether that domain stops while the processor is idle. The enable register holds static run bits for the internal timer clock and the external peripheral clock. The external reference clock and the timer/watchdog clock have no static enable, so they are stopped only by the idle policy.

Two plain inputs shape the result: `cpu_idle`, the processor's idle request, and `wdog_mode`, which says that the timer/watchdog unit is working as a watchdog. While `wdog_mode` is high the timer/watchdog clock enable is held high, whatever the idle policy says. Each domain's enable goes to a glitch-free clock-gating cell that lies outside this block.

The request port uses valid/ready. `req_ready` is tied high, so a request is accepted in every cycle in which `req_valid` is high. A read returns its data one cycle later with `rsp_valid`. There is no back-pressure on the response.

Top module: `clk_idle_gate_ctrl`

## Requirements
- R1: `ce_xref` is low after any cycle in which `cpu_idle` was high and bit 1 of the idle-policy register (offset 0x04) was set. Otherwise it is high.
- R2: `ce_wdt` follows bit 0 of the idle-policy register in the same way as R1, provided `wdog_mode` was low.
- R3: `ce_wdt` is high after any cycle in which `wdog_mode` was high, whatever the idle state and the register contents.
- R4: `ce_tim` is high only if bit 5 of the enable register (offset 0x08) was set and it is not the case that `cpu_idle` was high with bit 2 of the idle-policy register set.
- R5: `ce_per` is high only if bit 2 of the enable register was set and it is not the case that `cpu_idle` was high with bit 3 of the idle-policy register set.
- R6: Register bits that are not defined read as 0, and writing them changes nothing. The idle-policy register keeps bits 3:0. The enable register keeps bits 5 and 2.
- R7: While reset is active, and right after it, both registers hold 0, `ce_xref` and `ce_wdt` are high, `ce_tim` and `ce_per` are low, and `rsp_valid` is low.
- R8: An accepted read raises `rsp_valid` in the next cycle with the register contents. A read from any offset other than 0x04 or 0x08 returns 0. A write to such an offset has no effect.
- R9: Every enable is a register. The enable depends on the inputs and the register contents at one rising edge and appears after that edge. A write that lands at an edge first affects the enables at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 16 | Read data |
| cpu_idle | input | 1 | Processor idle request |
| wdog_mode | input | 1 | Timer/watchdog unit is in watchdog mode |
| ce_xref | output | 1 | Clock enable, external reference peripheral clock |
| ce_wdt | output | 1 | Clock enable, timer/watchdog clock |
| ce_tim | output | 1 | Clock enable, internal timer clock |
| ce_per | output | 1 | Clock enable, external peripheral clock |

## Verification
If a policy or enable bit is stored wrong, the fault shows on the matching enable output at the first edge where idle is high or the static bit matters. The same wrong value also shows on the very next read of that register. A wrong mask or address decode shows on a read one cycle after the access. A missed watchdog override shows at the first edge with idle high, bit 0 of the policy register set and `wdog_mode` high. Random traffic reaches these combinations within a few tens of cycles.

// File: rtl/clkg_pkg.sv
package clkg_pkg;
  localparam int NUM_DOM = 4;
  localparam int DOM_WDT  = 0;
  localparam int DOM_XREF = 1;
  localparam int DOM_TIM  = 2;
  localparam int DOM_PER  = 3;
  typedef logic [NUM_DOM-1:0] dom_vec_t;
endpackage

// File: rtl/clkg_regs.sv
module clkg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] POL_OFF = 8'h04,
  parameter logic [ADDR_W-1:0] EN_OFF  = 8'h08,
  parameter logic [DATA_W-1:0] POL_MASK = 16'h000F,
  parameter logic [DATA_W-1:0] EN_MASK  = 16'h0024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] en_q
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic hit_pol, hit_en, do_wr, do_rd;
  logic [DATA_W-1:0] rd_mux;

  assign hit_pol = (req_addr == POL_OFF);
  assign hit_en  = (req_addr == EN_OFF);
  assign do_wr   = req_valid && req_wr;
  assign do_rd   = req_valid && !req_wr;

  always_comb begin
    rd_mux = ZERO;
    if (hit_pol) rd_mux = pol_q;
    else if (hit_en) rd_mux = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q     <= ZERO;
      en_q      <= ZERO;
      rsp_valid <= 1'b0;
      rsp_rdata <= ZERO;
    end else begin
      if (do_wr && hit_pol) pol_q <= req_wdata & POL_MASK;
      if (do_wr && hit_en)  en_q  <= req_wdata & EN_MASK;
      rsp_valid <= do_rd;
      rsp_rdata <= do_rd ? rd_mux : ZERO;
    end
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~(POL_MASK | EN_MASK)) == ZERO)); // R6
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr) |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_wr) |=> !rsp_valid); // R8
endmodule

// File: rtl/clkg_gate.sv
module clkg_gate
  import clkg_pkg::*;
#(
  parameter dom_vec_t FORCE_MASK = 4'b0001,
  parameter dom_vec_t RESET_CE   = 4'b0011
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_idle,
  input  logic     wdog_mode,
  input  dom_vec_t static_en,
  input  dom_vec_t idle_sel,
  output dom_vec_t ce_q
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic run_d;
    if (FORCE_MASK[d]) begin : g_forced
      assign run_d = wdog_mode || (static_en[d] && !(cpu_idle && idle_sel[d]));
    end else begin : g_plain
      assign run_d = static_en[d] && !(cpu_idle && idle_sel[d]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_q[d] <= RESET_CE[d];
      else        ce_q[d] <= run_d;
    end
  end
endmodule

// File: rtl/clk_idle_gate_ctrl.sv
module clk_idle_gate_ctrl
  import clkg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int TIM_EN_BIT = 5,
  parameter int PER_EN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cpu_idle,
  input  logic              wdog_mode,
  output logic              ce_xref,
  output logic              ce_wdt,
  output logic              ce_tim,
  output logic              ce_per
);
  localparam logic [DATA_W-1:0] POL_MASK = DATA_W'((1 << NUM_DOM) - 1);
  localparam logic [DATA_W-1:0] EN_MASK  =
    DATA_W'((1 << TIM_EN_BIT) | (1 << PER_EN_BIT));
  localparam dom_vec_t FORCE = dom_vec_t'(1 << DOM_WDT);
  localparam dom_vec_t RST_CE = dom_vec_t'((1 << DOM_WDT) | (1 << DOM_XREF));

  logic [DATA_W-1:0] pol_q, en_q;
  dom_vec_t static_en, idle_sel, ce_q;

  assign req_ready = 1'b1;

  clkg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .POL_OFF(ADDR_W'(4)), .EN_OFF(ADDR_W'(8)),
    .POL_MASK(POL_MASK), .EN_MASK(EN_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pol_q(pol_q), .en_q(en_q)
  );

  always_comb begin
    static_en = '1;
    static_en[DOM_TIM] = en_q[TIM_EN_BIT];
    static_en[DOM_PER] = en_q[PER_EN_BIT];
    idle_sel = pol_q[NUM_DOM-1:0];
  end

  clkg_gate #(.FORCE_MASK(FORCE), .RESET_CE(RST_CE)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .cpu_idle(cpu_idle), .wdog_mode(wdog_mode),
    .static_en(static_en), .idle_sel(idle_sel),
    .ce_q(ce_q)
  );

  assign ce_wdt  = ce_q[DOM_WDT];
  assign ce_xref = ce_q[DOM_XREF];
  assign ce_tim  = ce_q[DOM_TIM];
  assign ce_per  = ce_q[DOM_PER];

  AST_XREF_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_idle && pol_q[DOM_XREF]) |=> !ce_xref); // R1
  AST_WDT_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_idle && pol_q[DOM_WDT] && !wdog_mode) |=> !ce_wdt); // R2
  AST_WDT_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_mode |=> ce_wdt); // R3
  AST_TIM_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[TIM_EN_BIT] |=> !ce_tim); // R4
  AST_PER_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[PER_EN_BIT] |=> !ce_per); // R5
  AST_AWAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_idle |=> ce_xref); // R9
endmodule

// File: tb/tb_clk_idle_gate_ctrl.sv
module tb_clk_idle_gate_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_wr = 0, cpu_idle = 0, wdog_mode = 0;
  logic [7:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rsp_valid, ce_xref, ce_wdt, ce_tim, ce_per;
  logic [15:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [15:0] m_pol = 0, m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_idle_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cpu_idle(cpu_idle), .wdog_mode(wdog_mode),
    .ce_xref(ce_xref), .ce_wdt(ce_wdt), .ce_tim(ce_tim), .ce_per(ce_per)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [7:0] a);
    if (a == 8'h04) return m_pol;
    if (a == 8'h08) return m_en;
    return 16'h0;
  endfunction

  task automatic step(input logic idl, input logic wd, input logic v,
                      input logic w, input logic [7:0] a, input logic [15:0] d);
    logic e_x, e_w, e_t, e_p;
    logic [15:0] e_rd;
    e_x = !(idl && m_pol[1]);
    e_w = wd || !(idl && m_pol[0]);
    e_t = m_en[5] && !(idl && m_pol[2]);
    e_p = m_en[2] && !(idl && m_pol[3]);
    e_rd = model_read(a);
    cpu_idle = idl; wdog_mode = wd; req_valid = v; req_wr = w;
    req_addr = a; req_wdata = d;
    if (v && w && a == 8'h04) m_pol = d & 16'h000F;
    if (v && w && a == 8'h08) m_en  = d & 16'h0024;
    @(negedge clk);
    chk("R1 ce_xref", {15'd0, ce_xref}, {15'd0, e_x});
    chk(wd ? "R3 ce_wdt forced" : "R2 ce_wdt", {15'd0, ce_wdt}, {15'd0, e_w});
    chk("R4 ce_tim", {15'd0, ce_tim}, {15'd0, e_t});
    chk("R5 ce_per", {15'd0, ce_per}, {15'd0, e_p});
    chk("R8 rsp_valid", {15'd0, rsp_valid}, {15'd0, v && !w});
    if (v && !w) chk("R6 R8 rsp_rdata", rsp_rdata, e_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [4];
    addrs[0] = 8'h04; addrs[1] = 8'h08; addrs[2] = 8'h0C; addrs[3] = 8'h00;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    // R7 reset state
    chk("R7 ce_xref", {15'd0, ce_xref}, 16'd1);
    chk("R7 ce_wdt", {15'd0, ce_wdt}, 16'd1);
    chk("R7 ce_tim", {15'd0, ce_tim}, 16'd0);
    chk("R7 ce_per", {15'd0, ce_per}, 16'd0);
    chk("R7 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    rst_n = 1'b1;
    step(0, 0, 1, 0, 8'h04, 0);          // R7 regs read 0
    step(0, 0, 1, 0, 8'h08, 0);
    // R6 reserved bits ignored
    step(0, 0, 1, 1, 8'h04, 16'hFFFF);
    step(0, 0, 1, 1, 8'h08, 16'hFFFF);
    step(0, 0, 1, 0, 8'h04, 0);
    step(0, 0, 1, 0, 8'h08, 0);
    // R8 undefined offset write ignored, read 0
    step(0, 0, 1, 1, 8'h0C, 16'h0000);
    step(1, 0, 1, 0, 8'h0C, 0);
    step(1, 1, 1, 0, 8'h04, 0);           // R3 forced
    step(1, 0, 0, 0, 8'h00, 0);           // R2 stop
    // R9 write at an edge affects next edge only
    step(1, 0, 1, 1, 8'h04, 16'h0000);
    step(1, 0, 0, 0, 8'h00, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] & r[2], r[3] | r[4], r[5], addrs[r[7:6]], $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule